// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block is the bus engine of a single-master I2C controller. Software writes one-shot set pulses for four request bits: start, transmit, receive and stop. The engine carries them out on SCL and on an open-drain SDA, which it drives as a pull-down enable and reads back through an input. The engine clears each request bit by itself once that request has been served. A transmit byte carries the slave address and its direction bit, or any other byte, MSB first. The slave's acknowledge is captured on the ninth clock. A receive byte releases SDA for eight clocks, samples it on each SCL rising edge and then drives a programmable ACK or NACK on the ninth clock. The received byte lands in a data register with a ready flag, a busy flag and a one-cycle interrupt pulse. SCL timing comes from a fixed divider: every SCL half period lasts `HALF_CYCLES` clock cycles.

The controller has nine states. `ST_IDLE` is a free bus with both lines released. It moves to `ST_START_A` when a start is requested. `ST_START_A` holds SDA low with SCL high for one half period, then moves to `ST_START_B`. `ST_START_B` pulls SCL low, clears the start request and enters `ST_HOLD`. `ST_HOLD` owns the bus with both lines low and picks the next action in this order: a pending transmit, then a pending receive, then a stop. A stop is taken only if start, transmit and receive are all clear. A byte toggles between `ST_BIT_LO` (SCL low, SDA set up) and `ST_BIT_HI` (SCL high). Each `ST_BIT_LO` to `ST_BIT_HI` edge is a sampling point. After the ninth `ST_BIT_HI` the engine returns to `ST_HOLD`. A stop runs `ST_STOP_A` (both low), then `ST_STOP_B` (SCL high, SDA low), then `ST_STOP_C` (SDA released), and goes back to `ST_IDLE` with the stop request cleared. There is no repeated start: a start request raised while the bus is held stays pending.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, SCL is high, SDA is released (`sda_oe`=0), and every request bit, `rx_ready`, `rx_busy`, `rx_irq` and `ack_seen` are 0.
- R2: A start request on a free bus pulls SDA low while SCL stays high, then pulls SCL low. The start request then clears, and the bus is held with SCL low and SDA low.
- R3: A transmit byte goes out MSB first, and SDA changes only while SCL is low. On the ninth clock the engine releases SDA and captures the sampled level into `ack_seen` (0 = ACK, 1 = NACK). The transmit request clears after that ninth clock.
- R4: If transmit and receive are both pending, the transmit byte is sent first and the receive byte follows it.
- R5: A receive byte releases SDA for eight clocks and samples it on each SCL rising edge, MSB first. The byte is then copied to `rx_data` and `rx_ready` goes to 1.
- R6: The receive request clears on the SCL rising edge that samples the second data bit.
- R7: `rx_busy` is 1 from the start of a receive byte until the byte is copied to `rx_data`, and 0 at all other times.
- R8: On the ninth clock of a receive byte, the engine drives SDA low when `ack_level`=0 (ACK) and releases it when `ack_level`=1 (NACK).
- R9: A `rx_read` pulse clears `rx_ready`. `rx_irq` pulses for one cycle on each load that finds `rx_ready` at 0.
- R10: A byte that completes while `rx_ready` is 1 overwrites `rx_data` and raises no error. A load in the same cycle as `rx_read` leaves `rx_ready` at 1.
- R11: A stop request, with start, transmit and receive all clear after the last byte, produces SDA rising while SCL is high. The stop request then clears and both lines stay released.
- R12: While the bus is held, a stop request has no effect as long as any of start, transmit or receive is pending, and a new start request is not acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_set | input | 1 | Sets the start request |
| tx_set | input | 1 | Sets the transmit request |
| rx_set | input | 1 | Sets the receive request |
| stop_set | input | 1 | Sets the stop request |
| tx_data | input | 8 | Byte to transmit, latched when the byte begins |
| ack_level | input | 1 | Ninth-bit level for receive: 0 ACK, 1 NACK |
| rx_read | input | 1 | Read strobe of `rx_data`; clears `rx_ready` |
| sda_i | input | 1 | SDA line level |
| scl_o | output | 1 | SCL level (1 = high) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| start_pend | output | 1 | Start request bit |
| tx_pend | output | 1 | Transmit request bit |
| rx_pend | output | 1 | Receive request bit |
| stop_pend | output | 1 | Stop request bit |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | Unread byte in `rx_data` |
| rx_busy | output | 1 | Receive byte in progress |
| rx_irq | output | 1 | One-cycle receive interrupt pulse |
| ack_seen | output | 1 | Acknowledge level captured on the last transmit byte |

## Verification
The two functions that can land in the same cycle are the copy of a finished receive byte into `rx_data` and a software read strobe. The bench provokes the overlap on a byte that arrives while the previous byte is still unread. It times `rx_read` from the SCL low phase before the eighth rising edge, so the strobe is present at exactly the clock edge where the byte loads. The result is judged at the ports: `rx_ready` must stay 1, `rx_data` must hold the new byte, and no interrupt pulse may appear, since the flag never passed through 0.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int unsigned BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A,
        ST_START_B,
        ST_HOLD,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } bus_state_t;

endpackage

// File: rtl/i2cm_phase.sv
module i2cm_phase #(
    parameter int unsigned HALF_CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic phase_end
);
    localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign phase_end = !hold && (cnt == LAST);

endmodule

// File: rtl/i2cm_rxbuf.sv
module i2cm_rxbuf #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         rd,
    output logic [W-1:0] dout,
    output logic         ready,
    output logic         irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= '0;
            ready <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= load && !ready;
            if (load) begin
                dout  <= din;
                ready <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end
        end
    end

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ready);

    // R10
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(din));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> !ready);

    // R9
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ready && !$past(ready)));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 50
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_set,
    input  logic                 tx_set,
    input  logic                 rx_set,
    input  logic                 stop_set,
    input  logic [BYTE_BITS-1:0] tx_data,
    input  logic                 ack_level,
    input  logic                 rx_read,
    input  logic                 sda_i,
    output logic                 scl_o,
    output logic                 sda_oe,
    output logic                 start_pend,
    output logic                 tx_pend,
    output logic                 rx_pend,
    output logic                 stop_pend,
    output logic [BYTE_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 rx_busy,
    output logic                 rx_irq,
    output logic                 ack_seen
);
    localparam int unsigned CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] RXE_SLOT  = CNT_W'(1);

    bus_state_t           state, nxt;
    logic [CNT_W-1:0]     bitcnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 is_rx, ack_q;
    logic                 stt_q, txe_q, rxe_q, stp_q;
    logic                 phase_end, sample, bit_end, rx_load;

    i2cm_phase #(.HALF_CYCLES(HALF_CYCLES)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (state == ST_IDLE || state == ST_HOLD),
        .phase_end (phase_end)
    );

    assign sample  = (state == ST_BIT_LO) && phase_end;
    assign bit_end = (state == ST_BIT_HI) && phase_end;
    assign rx_load = sample && is_rx && (bitcnt == LAST_DATA);

    i2cm_rxbuf #(.W(BYTE_BITS)) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rx_load),
        .din   ({shreg[BYTE_BITS-2:0], sda_i}),
        .rd    (rx_read),
        .dout  (rx_data),
        .ready (rx_ready),
        .irq   (rx_irq)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (stt_q) nxt = ST_START_A;
            ST_START_A: if (phase_end) nxt = ST_START_B;
            ST_START_B: if (phase_end) nxt = ST_HOLD;
            ST_HOLD: begin
                if (txe_q || rxe_q)     nxt = ST_BIT_LO;
                else if (stp_q && !stt_q) nxt = ST_STOP_A;
            end
            ST_BIT_LO:  if (phase_end) nxt = ST_BIT_HI;
            ST_BIT_HI:  if (phase_end) nxt = (bitcnt == ACK_SLOT) ? ST_HOLD : ST_BIT_LO;
            ST_STOP_A:  if (phase_end) nxt = ST_STOP_B;
            ST_STOP_B:  if (phase_end) nxt = ST_STOP_C;
            ST_STOP_C:  if (phase_end) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stt_q <= 1'b0; txe_q <= 1'b0; rxe_q <= 1'b0; stp_q <= 1'b0;
            bitcnt <= '0; shreg <= '0; is_rx <= 1'b0; ack_q <= 1'b0;
            rx_busy <= 1'b0; ack_seen <= 1'b0;
        end else begin
            stt_q <= start_set || (stt_q && !(state == ST_START_B && phase_end));
            txe_q <= tx_set || (txe_q && !(bit_end && bitcnt == ACK_SLOT && !is_rx));
            rxe_q <= rx_set || (rxe_q && !(sample && is_rx && bitcnt == RXE_SLOT));
            stp_q <= stop_set || (stp_q && !(state == ST_STOP_C && phase_end));
            if (state == ST_HOLD && txe_q) begin
                is_rx  <= 1'b0;
                shreg  <= tx_data;
                bitcnt <= '0;
            end else if (state == ST_HOLD && rxe_q) begin
                is_rx   <= 1'b1;
                ack_q   <= ack_level;
                bitcnt  <= '0;
                rx_busy <= 1'b1;
            end
            if (sample) begin
                if (is_rx && bitcnt != ACK_SLOT) shreg <= {shreg[BYTE_BITS-2:0], sda_i};
                if (!is_rx && bitcnt == ACK_SLOT) ack_seen <= sda_i;
            end
            if (rx_load) rx_busy <= 1'b0;
            if (bit_end) begin
                bitcnt <= (bitcnt == ACK_SLOT) ? '0 : bitcnt + 1'b1;
                if (!is_rx) shreg <= {shreg[BYTE_BITS-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        scl_o  = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_IDLE:    begin scl_o = 1'b1; sda_oe = 1'b0; end
            ST_START_A: begin scl_o = 1'b1; sda_oe = 1'b1; end
            ST_START_B: begin scl_o = 1'b0; sda_oe = 1'b1; end
            ST_HOLD:    begin scl_o = 1'b0; sda_oe = 1'b1; end
            ST_BIT_LO, ST_BIT_HI: begin
                scl_o = (state == ST_BIT_HI);
                if (bitcnt == ACK_SLOT) sda_oe = is_rx && !ack_q;
                else                    sda_oe = !is_rx && !shreg[BYTE_BITS-1];
            end
            ST_STOP_A:  begin scl_o = 1'b0; sda_oe = 1'b1; end
            ST_STOP_B:  begin scl_o = 1'b1; sda_oe = 1'b1; end
            ST_STOP_C:  begin scl_o = 1'b1; sda_oe = 1'b0; end
            default:    begin scl_o = 1'b1; sda_oe = 1'b0; end
        endcase
    end

    assign start_pend = stt_q;
    assign tx_pend    = txe_q;
    assign rx_pend    = rxe_q;
    assign stop_pend  = stp_q;

    // R12
    stop_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && (stt_q || txe_q || rxe_q)) |=> (state != ST_STOP_A));

    // R12
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_START_A) |=> (state != ST_START_A));

    // R3
    sda_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT_HI && $past(state) == ST_BIT_HI) |-> $stable(sda_oe));

    // R6
    rxe_clear_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxe_q) |-> (is_rx && state == ST_BIT_HI && bitcnt == RXE_SLOT));

    // R7
    busy_in_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |-> (is_rx && (state == ST_BIT_LO || state == ST_BIT_HI)));

endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic start_set = 0, tx_set = 0, rx_set = 0, stop_set = 0;
    logic [7:0] tx_data = 8'h00;
    logic ack_level = 1'b0;
    logic rd_task = 1'b0, rd_auto = 1'b0;
    logic pull = 1'b0;
    logic sda_i;
    logic scl_o, sda_oe, start_pend, tx_pend, rx_pend, stop_pend;
    logic [7:0] rx_data;
    logic rx_ready, rx_busy, rx_irq, ack_seen;

    assign sda_i = !(sda_oe || pull);

    i2c_byte_master #(.HALF_CYCLES(HALF)) i_i2c_byte_master (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .tx_set(tx_set),
        .rx_set(rx_set), .stop_set(stop_set), .tx_data(tx_data),
        .ack_level(ack_level), .rx_read(rd_task || rd_auto), .sda_i(sda_i),
        .scl_o(scl_o), .sda_oe(sda_oe), .start_pend(start_pend),
        .tx_pend(tx_pend), .rx_pend(rx_pend), .stop_pend(stop_pend),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_busy(rx_busy),
        .rx_irq(rx_irq), .ack_seen(ack_seen)
    );

    int checks = 0, fails = 0;
    int byte_q[$];
    int ev_q[$];
    logic [31:0] send_mask = 32'h0;
    logic [7:0] slave_byte = 8'h00;
    logic slave_ack = 1'b0;
    logic arm = 1'b0;
    int bitidx = 0, nbytes = 0, lowcnt = 0, cur = 0, irq_cnt = 0;
    int rxe_fall_idx = -1, busy_at_fall = -1;
    logic prev_scl = 1'b1, prev_sda = 1'b1, prev_rxp = 1'b0;

    // Bus-level reference model: decodes conditions and bits, plays the slave
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_o && prev_scl && sda_i != prev_sda) begin
                if (!sda_i) begin
                    ev_q.push_back(1); bitidx = 0; cur = 0; nbytes = 0;
                end else begin
                    ev_q.push_back(2);
                end
            end
            if (scl_o && !prev_scl) begin
                cur = ((cur << 1) | int'(sda_i)) & 32'h1FF;
                bitidx++;
                if (bitidx == 9) begin
                    byte_q.push_back(cur); bitidx = 0; nbytes++;
                end
            end
            if (prev_rxp && !rx_pend) begin
                rxe_fall_idx = bitidx; busy_at_fall = int'(rx_busy);
            end
            if (rx_irq) irq_cnt++;
            if (!scl_o) lowcnt++; else lowcnt = 0;
            rd_auto <= arm && !scl_o && bitidx == 7 && send_mask[nbytes] && lowcnt == HALF;
            if (!scl_o) begin
                if (send_mask[nbytes] && bitidx < 8)       pull = !slave_byte[7 - bitidx];
                else if (!send_mask[nbytes] && bitidx == 8) pull = slave_ack;
                else                                         pull = 1'b0;
            end
            prev_scl = scl_o;
            prev_sda = !(sda_oe || pull);
            prev_rxp = rx_pend;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit s, input bit t, input bit r, input bit p);
        @(negedge clk);
        start_set = s; tx_set = t; rx_set = r; stop_set = p;
        @(negedge clk);
        start_set = 0; tx_set = 0; rx_set = 0; stop_set = 0;
    endtask

    task automatic wait_bytes(input int n);
        while (byte_q.size() < n) @(negedge clk);
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_task = 1;
        @(negedge clk); rd_task = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 50000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        send_mask = 32'h5E; // bytes 1,2,3,4,6 after the start are slave-driven reads
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl", int'(scl_o), 1);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 requests", int'({start_pend, tx_pend, rx_pend, stop_pend}), 0);
        chk("R1 status", int'({rx_ready, rx_busy, rx_irq, ack_seen}), 0);

        // R2 start
        pulse(1, 0, 0, 0);
        while (start_pend) @(negedge clk);
        @(negedge clk);
        chk("R2 start event", ev_q.size() == 1 ? ev_q[0] : -1, 1);
        chk("R2 bus held", int'({scl_o, sda_oe}), 1);

        // R3 address byte, slave acks
        tx_data = 8'h91; slave_ack = 1;
        pulse(0, 1, 0, 0);
        wait_bytes(1);
        chk("R3 address bits", byte_q[0], (8'h91 << 1) | 0);
        chk("R3 ack captured", int'(ack_seen), 0);
        chk("R3 tx request cleared", int'(tx_pend), 0);

        // R5 R6 R7 R8 R9 receive with ACK
        slave_byte = 8'h3C; ack_level = 0;
        pulse(0, 0, 1, 0);
        wait_bytes(2);
        chk("R5 rx_data", int'(rx_data), 8'h3C);
        chk("R5 rx_ready", int'(rx_ready), 1);
        chk("R8 ack driven low", byte_q[1], (8'h3C << 1) | 0);
        chk("R6 rx request clear point", rxe_fall_idx, 2);
        chk("R7 busy during byte", busy_at_fall, 1);
        chk("R7 busy after load", int'(rx_busy), 0);
        chk("R9 irq pulse count", irq_cnt, 1);
        do_read();
        @(negedge clk);
        chk("R9 read clears ready", int'(rx_ready), 0);

        // R8 NACK and R10 overwrite
        ack_level = 1; slave_byte = 8'hE7;
        pulse(0, 0, 1, 0);
        wait_bytes(3);
        slave_byte = 8'h5A;
        pulse(0, 0, 1, 0);
        wait_bytes(4);
        chk("R8 nack released", byte_q[3], (8'h5A << 1) | 1);
        chk("R10 overwrite data", int'(rx_data), 8'h5A);
        chk("R10 overwrite irq count", irq_cnt, 2);

        // R10 read strobe on the load edge
        slave_byte = 8'h81; arm = 1;
        pulse(0, 0, 1, 0);
        wait_bytes(5);
        arm = 0;
        chk("R10 collide ready kept", int'(rx_ready), 1);
        chk("R10 collide data", int'(rx_data), 8'h81);
        chk("R10 collide no irq", irq_cnt, 2);
        do_read();

        // R4 transmit before receive
        tx_data = 8'h6E; slave_byte = 8'hC3; ack_level = 0; slave_ack = 1;
        pulse(0, 1, 1, 0);
        wait_bytes(7);
        chk("R4 first byte is transmit", byte_q[5], (8'h6E << 1) | 0);
        chk("R4 then receive", int'(rx_data), 8'hC3);
        chk("R4 receive irq", irq_cnt, 3);

        // R11 R12 stop waits for transmit, slave NACKs
        tx_data = 8'h42; slave_ack = 0;
        pulse(0, 1, 0, 1);
        wait_bytes(8);
        while (stop_pend) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R3 nack captured", int'(ack_seen), 1);
        chk("R12 byte before stop", byte_q[7], (8'h42 << 1) | 1);
        chk("R11 conditions seen", ev_q.size() == 2 ? ev_q[1] : -1, 2);
        chk("R11 bus released", int'({scl_o, sda_oe}), 2);

        // R12 no repeated start, stop blocked by pending start
        pulse(1, 0, 0, 0);
        while (start_pend) @(negedge clk);
        pulse(1, 0, 0, 1);
        repeat (20 * HALF) @(negedge clk);
        chk("R12 no new condition", ev_q.size(), 3);
        chk("R12 requests stay pending", int'({start_pend, stop_pend}), 3);
        chk("R12 bus still held", int'(scl_o), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule